// File: doc/BRIEF.md
# Local Wake-Up Input Controller

This block watches four digital wake-up pins on behalf of a low-power supervisory controller. Software sets up the pins in two pairs through a 4-bit write strobe. Each pair can be switched off, or made sensitive to a high level, to a low level, or to any change of level. While the controller sits in one of its two low-power modes, an enabled pin that meets its sensitivity latches a per-pin wake flag. The block then raises a wake request toward the mode controller.

The 4-bit read-back has two meanings. After a wake it reports which pins caused the wake. The first read hands over those flags, and after that read the bits follow the live, synchronized pin levels. In the two active modes the pins serve only as a plain input port. A watchdog timeout that comes before the first read discards the flags. A read in the same cycle as a timeout wins: it returns the flags and then switches the bits to live levels.

Top module: `wake_input_ctrl`

## Requirements
- R1: After reset both configuration fields are 00, no flag is set, `wakeReq` is 0, and `rdData` reads 0 even when pins are high.
- R2: Write bits 1:0 configure pins 0 and 1 together, and write bits 3:2 configure pins 2 and 3 together.
- R3: Field code 01 wakes on a high pin and code 10 wakes on a low pin. A wake happens only in sleep (`pwrMode`=10) or stop (`pwrMode`=11).
- R4: Field code 11 wakes when the synchronized pin changes in either direction while in sleep or stop.
- R5: A pin in a pair with code 00 never sets its flag, and its live bit reads 0.
- R6: After a wake, `rdData` bit i is 1 exactly when pin i set its flag. This view holds until the first read, and the read cycle returns the flags.
- R7: After that read, `rdData` bit i shows the synchronized level of pin i, masked by its pair being enabled.
- R8: A `wdTimeout` pulse after a wake and before the first read clears all flags. The read-back then shows 0 until it is read.
- R9: When `rdEn` and `wdTimeout` arrive in the same cycle, that cycle returns the flags, and the bits show live levels afterwards.
- R10: `wakeReq` rises one cycle after the first flag appears. It stays high while the mode is sleep or stop and is 0 one cycle after the mode leaves them.
- R11: In normal (`pwrMode`=00) and standby (`pwrMode`=01) no flag is set and `wakeReq` stays 0.
- R12: Every pin passes through two flops: a change driven before an edge shows in the live view after the second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset; clears configuration and flags |
| pwrMode | input | 2 | 00 normal, 01 standby, 10 sleep, 11 stop |
| cfgWrEn | input | 1 | Write strobe for the configuration |
| cfgWrData | input | 4 | Configuration: bits 1:0 for pins 0/1, bits 3:2 for pins 2/3 |
| rdEn | input | 1 | Read strobe; marks the cycle in which `rdData` is taken |
| rdData | output | 4 | Wake flags or live pin levels, one bit per pin |
| wdTimeout | input | 1 | Single-cycle watchdog timeout pulse |
| wakeIn | input | 4 | Asynchronous wake pins |
| wakeReq | output | 1 | Wake request to the mode controller |

## Verification
The hardest case to reach is a timeout that finds flags still unread. A level-sensitive pin that is still active re-latches its flag on the very next cycle, so the clear would never be visible. The stimulus therefore uses the any-change setting and pulses one pin away from rest and back. The flag stays set while the pin sits at its rest level again, so the timeout, and a combined read and timeout, can both be seen on the read-back. A sweep over all 16 configuration words and all 16 pin patterns covers the pairing, every sensitivity code and the two-step read behaviour.

// File: rtl/wic_pkg.sv
package wic_pkg;
  typedef enum logic [1:0] {
    SENS_OFF  = 2'b00,
    SENS_HIGH = 2'b01,
    SENS_LOW  = 2'b10,
    SENS_BOTH = 2'b11
  } sens_e;

  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'b00,
    MODE_STANDBY = 2'b01,
    MODE_SLEEP   = 2'b10,
    MODE_STOP    = 2'b11
  } pwrMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cfgWr;
    logic clrFlags;
    logic viewLatched;
  } wicStrobe_t;
endpackage

// File: rtl/wic_datapath.sv
module wic_datapath
  import wic_pkg::*;
#(
  parameter int NUM_IN   = 4,
  parameter int GRP_SIZE = 2,
  parameter int CFG_W    = 2,
  localparam int NUM_GRP = NUM_IN / GRP_SIZE,
  localparam int WORD_W  = NUM_GRP * CFG_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  wicStrobe_t        strb,
  input  logic [WORD_W-1:0] wrData,
  input  logic              lowPower,
  input  logic [NUM_IN-1:0] pinIn,
  output logic [NUM_IN-1:0] rdData,
  output logic [NUM_IN-1:0] flags,
  output logic [WORD_W-1:0] cfgWord,
  output logic              anyHit
);
  logic [NUM_IN-1:0] syncA, syncB, prevB;
  logic [NUM_IN-1:0] hit, liveMask;
  logic [WORD_W-1:0] cfgQ;
  logic [NUM_IN-1:0] flagsQ;

  // two-flop synchronizer plus one history stage for change detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevB <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
      prevB <= syncB;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           cfgQ <= '0;
    else if (strb.cfgWr) cfgQ <= wrData;
  end

  for (genvar i = 0; i < NUM_IN; i++) begin : g_pin
    localparam int GI = i / GRP_SIZE;
    sens_e sens;
    assign sens = sens_e'(cfgQ[GI*CFG_W +: CFG_W]);
    assign liveMask[i] = (sens != SENS_OFF);
    always_comb begin
      unique case (sens)
        SENS_HIGH: hit[i] = lowPower & syncB[i];
        SENS_LOW:  hit[i] = lowPower & ~syncB[i];
        SENS_BOTH: hit[i] = lowPower & (syncB[i] ^ prevB[i]);
        default:   hit[i] = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagsQ <= '0;
    else       flagsQ <= (strb.clrFlags ? '0 : flagsQ) | hit;
  end

  assign rdData  = strb.viewLatched ? flagsQ : (syncB & liveMask);
  assign flags   = flagsQ;
  assign cfgWord = cfgQ;
  assign anyHit  = |hit;
endmodule

// File: rtl/wic_ctrl.sv
module wic_ctrl
  import wic_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWrEn,
  input  logic       rdEn,
  input  logic       wdTimeout,
  input  logic       lowPower,
  input  logic       anyHit,
  input  logic       anyFlag,
  output wicStrobe_t strb,
  output logic       wakeReq
);
  logic viewQ, wakeQ;

  // flag view holds from a wake until the first read; a new wake re-arms it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      viewQ <= 1'b0;
      wakeQ <= 1'b0;
    end else begin
      viewQ <= (viewQ & ~rdEn) | anyHit;
      wakeQ <= lowPower & (wakeQ | anyFlag);
    end
  end

  always_comb begin
    strb.cfgWr       = cfgWrEn;
    strb.clrFlags    = viewQ & (rdEn | wdTimeout);
    strb.viewLatched = viewQ;
  end

  assign wakeReq = wakeQ;
endmodule

// File: rtl/wake_input_ctrl.sv
module wake_input_ctrl
  import wic_pkg::*;
#(
  parameter int NUM_IN   = 4,
  parameter int GRP_SIZE = 2,
  localparam int CFG_W   = 2,
  localparam int WORD_W  = (NUM_IN / GRP_SIZE) * CFG_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        pwrMode,
  input  logic              cfgWrEn,
  input  logic [WORD_W-1:0] cfgWrData,
  input  logic              rdEn,
  output logic [NUM_IN-1:0] rdData,
  input  logic              wdTimeout,
  input  logic [NUM_IN-1:0] wakeIn,
  output logic              wakeReq
);
  wicStrobe_t        strbW;
  logic [NUM_IN-1:0] flagsW;
  logic [WORD_W-1:0] cfgW;
  logic              anyHitW;
  logic              lowPowerW;
  logic              viewLatchedW;

  assign lowPowerW    = (pwrMode == MODE_SLEEP) || (pwrMode == MODE_STOP);
  assign viewLatchedW = strbW.viewLatched;

  wic_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .rdEn(rdEn),
    .wdTimeout(wdTimeout), .lowPower(lowPowerW), .anyHit(anyHitW),
    .anyFlag(|flagsW), .strb(strbW), .wakeReq(wakeReq)
  );

  wic_datapath #(.NUM_IN(NUM_IN), .GRP_SIZE(GRP_SIZE), .CFG_W(CFG_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strbW), .wrData(cfgWrData),
    .lowPower(lowPowerW), .pinIn(wakeIn), .rdData(rdData),
    .flags(flagsW), .cfgWord(cfgW), .anyHit(anyHitW)
  );
endmodule

// File: rtl/wic_checker.sv
module wic_checker #(
  parameter int NUM_IN = 4,
  parameter int WORD_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        pwrMode,
  input logic              rdEn,
  input logic              wdTimeout,
  input logic              wakeReq,
  input logic [NUM_IN-1:0] flags,
  input logic [WORD_W-1:0] cfgWord,
  input logic              anyHit,
  input logic              viewLatched
);
  logic lp;
  assign lp = pwrMode[1];

  assert_req_drops_R10: assert property (@(posedge clk) disable iff (!rstN)
    !lp |=> !wakeReq);

  assert_req_holds_R10: assert property (@(posedge clk) disable iff (!rstN)
    (wakeReq && lp) |=> wakeReq);

  assert_off_pair_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWord[1:0] == 2'b00 && flags[1:0] == 2'b00) |=> flags[1:0] == 2'b00);

  assert_active_no_wake_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!lp && flags == '0) |=> flags == '0);

  assert_wd_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    (viewLatched && wdTimeout && !anyHit) |=> flags == '0);

  assert_read_to_live_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !anyHit) |=> !viewLatched);
endmodule

bind wake_input_ctrl wic_checker #(.NUM_IN(NUM_IN), .WORD_W(WORD_W)) chk_i (
  .clk(clk), .rstN(rstN), .pwrMode(pwrMode), .rdEn(rdEn),
  .wdTimeout(wdTimeout), .wakeReq(wakeReq), .flags(flagsW),
  .cfgWord(cfgW), .anyHit(anyHitW), .viewLatched(viewLatchedW)
);

// File: tb/wake_input_ctrl_tb.sv
`timescale 1ns/1ps
module wake_input_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] pwrMode = 2'b00;
  logic       cfgWrEn = 1'b0;
  logic [3:0] cfgWrData = '0;
  logic       rdEn = 1'b0;
  logic [3:0] rdData;
  logic       wdTimeout = 1'b0;
  logic [3:0] wakeIn = '0;
  logic       wakeReq;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  wake_input_ctrl dut_i (
    .clk(clk), .rstN(rstN), .pwrMode(pwrMode), .cfgWrEn(cfgWrEn),
    .cfgWrData(cfgWrData), .rdEn(rdEn), .rdData(rdData),
    .wdTimeout(wdTimeout), .wakeIn(wakeIn), .wakeReq(wakeReq)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; pwrMode = 2'b00; wakeIn = '0; rdEn = 0; wdTimeout = 0; cfgWrEn = 0;
    tick(2);
    rstN = 1'b1;
    tick(1);
  endtask

  task automatic writeCfg(input logic [3:0] v);
    cfgWrEn = 1'b1; cfgWrData = v;
    tick(1);
    cfgWrEn = 1'b0;
  endtask

  task automatic readPulse(input string req, input logic [3:0] exp);
    rdEn = 1'b1;
    #1 chk(req, rdData, exp);
    tick(1);
    rdEn = 1'b0;
  endtask

  // expected flag from field code, pin pattern bit; pins rest low before the pattern
  function automatic logic expFlag(input logic [1:0] code, input logic p);
    case (code)
      2'b01:   return p;
      2'b10:   return 1'b1;
      2'b11:   return p;
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    // R1: reset state
    doReset();
    chk("R1 rdData", rdData, 4'b0000);
    chk("R1 wakeReq", {3'b0, wakeReq}, 4'b0000);
    wakeIn = 4'b1111;
    tick(4);
    chk("R1 disabled live", rdData, 4'b0000);

    // R12: two-flop latency in live view
    doReset();
    writeCfg(4'b0101);
    wakeIn = 4'b1111;
    tick(1);
    chk("R12 after one edge", rdData, 4'b0000);
    tick(1);
    chk("R12 after two edges", rdData, 4'b1111);

    // R11: active modes do not wake
    doReset();
    writeCfg(4'b0101);
    pwrMode = 2'b01;
    wakeIn = 4'b1011;
    tick(5);
    chk("R11 standby live", rdData, 4'b1011);
    chk("R11 standby wakeReq", {3'b0, wakeReq}, 4'b0000);
    pwrMode = 2'b00;
    writeCfg(4'b1010);
    wakeIn = 4'b0000;
    tick(5);
    chk("R11 normal live low-sens", rdData, 4'b0000);
    chk("R11 normal wakeReq", {3'b0, wakeReq}, 4'b0000);
    readPulse("R11 read live", 4'b0000);

    // R2 R3 R4 R5 R6 R7 R10: full sweep of config words and pin patterns
    for (int c = 0; c < 16; c++) begin
      for (int p = 0; p < 16; p++) begin
        logic [3:0] exp, mask, cfg, pat;
        cfg = 4'(c); pat = 4'(p);
        for (int i = 0; i < 4; i++) begin
          exp[i]  = expFlag(cfg[(i/2)*2 +: 2], pat[i]);
          mask[i] = (cfg[(i/2)*2 +: 2] != 2'b00);
        end
        doReset();
        writeCfg(cfg);
        tick(3);
        pwrMode = pat[0] ? 2'b11 : 2'b10;
        wakeIn = pat;
        tick(5);
        chk("R2/R3/R4/R5/R6 flags", rdData, exp);
        chk("R10 wakeReq level", {3'b0, wakeReq}, {3'b0, |exp});
        pwrMode = 2'b00;
        tick(1);
        chk("R10 wakeReq after exit", {3'b0, wakeReq}, 4'b0000);
        chk("R6 flags held in active mode", rdData, exp);
        readPulse("R6 read returns flags", exp);
        chk("R7/R5 live after read", rdData, pat & mask);
      end
    end

    // R10: exact rise timing
    doReset();
    writeCfg(4'b1111);
    pwrMode = 2'b11;
    tick(3);
    wakeIn = 4'b0010;
    tick(3);
    chk("R10 flag visible", rdData, 4'b0010);
    chk("R10 not yet raised", {3'b0, wakeReq}, 4'b0000);
    tick(1);
    chk("R10 raised next cycle", {3'b0, wakeReq}, 4'b0001);

    // R8: timeout before first read clears flags
    wakeIn = 4'b0000;
    tick(4);
    chk("R8 flag before timeout", rdData, 4'b0010);
    wdTimeout = 1'b1;
    tick(1);
    wdTimeout = 1'b0;
    chk("R8 cleared by timeout", rdData, 4'b0000);
    pwrMode = 2'b00;
    wakeIn = 4'b1000;
    tick(4);
    chk("R8 still flag view", rdData, 4'b0000);
    readPulse("R8 read returns cleared", 4'b0000);
    chk("R7 live after read", rdData, 4'b1000);
    wdTimeout = 1'b1;
    tick(1);
    wdTimeout = 1'b0;
    chk("R7 timeout after read no effect", rdData, 4'b1000);

    // R9: read and timeout in the same cycle
    doReset();
    writeCfg(4'b1111);
    pwrMode = 2'b10;
    tick(3);
    wakeIn = 4'b0100;
    tick(4);
    wakeIn = 4'b0000;
    tick(4);
    rdEn = 1'b1; wdTimeout = 1'b1;
    #1 chk("R9 read wins returns flags", rdData, 4'b0100);
    tick(1);
    rdEn = 1'b0; wdTimeout = 1'b0;
    chk("R9 live after combined", rdData, 4'b0000);
    pwrMode = 2'b00;
    wakeIn = 4'b0001;
    tick(3);
    chk("R9 live follows pin", rdData, 4'b0001);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule